// File: doc/BRIEF.md
# Mode-Banked Register File

This block holds the sixteen general registers of a 32-bit core whose stack pointer, link register and (for the fast-interrupt mode) the upper five general registers exist in several copies, one per processor mode. A mode controller tracks the active mode and turns each mode-change request into a one-cycle bank switch. The same register numbers then reach a different physical copy from the next cycle on. The block also owns the current status word. For each privileged exception mode it keeps a saved copy of the status word, which is captured when that mode is entered.

Two read ports and one write port take a 4-bit register number. Register 15 is not stored: a read of it returns the program counter that the core supplies on `pc_in`, and a write to it is dropped. A mode change is requested by raising `mode_req` for one cycle with the 5-bit target code on `mode_code`.

The controller is a state machine whose states are the seven modes: USR, FIQ, IRQ, SVC, ABT, UND and SYS. It has two kinds of transition. SWITCH is taken on a request whose target differs from the current mode, and it moves to the target state. HOLD is taken when there is no request or the target equals the current mode, and it keeps the state.

Top module: `mode_banked_regfile`

## Requirements
- R1: After reset the status word reads 0x6000001F (SYS mode), and every stored register, every banked copy and every saved status word is zero.
- R2: Mode codes are USR=10000, FIQ=10001, IRQ=10010, SVC=10011, ABT=10111, UND=11011, SYS=11111, and they sit in status bits [4:0]. A request with a legal code leaves that code in bits [4:0] on the next cycle. Bits [31:5] always keep their reset value.
- R3: Registers 13 and 14 have six copies. USR and SYS share copy 0, and FIQ, IRQ, SVC, ABT and UND each have their own. A value written in one mode is not seen in a mode that uses another copy, and it is seen again on return.
- R4: Registers 8 to 12 have one copy for FIQ and one for all other modes. Only switches into or out of FIQ change which copy they reach.
- R5: Registers 0 to 7 are the same in every mode.
- R6: A request whose target equals the current mode has no effect: the status word, the saved status words and all registers keep their values.
- R7: On a switch into FIQ, IRQ, SVC, ABT or UND, that mode's saved status word takes the status word held before the switch. The saved-status output gives the current mode's saved word, or the status word itself in USR and SYS.
- R8: A request with any code other than the seven legal ones is treated as a request for USR.
- R9: A write in the same cycle as a switch goes to the copy of the mode active before the switch.
- R10: Reads are combinational on the stored state, so a write becomes visible on the cycle after it. Reading register 15 returns `pc_in`, and writes to register 15 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| rd0_idx | input | 4 | Register number for read port 0 |
| rd0_data | output | 32 | Data from read port 0 |
| rd1_idx | input | 4 | Register number for read port 1 |
| rd1_data | output | 32 | Data from read port 1 |
| wr_en | input | 1 | Write enable |
| wr_idx | input | 4 | Register number to write |
| wr_data | input | 32 | Write data |
| pc_in | input | 32 | Program counter, returned for register 15 |
| mode_req | input | 1 | Mode-change request, one cycle |
| mode_code | input | 5 | Target mode code |
| cpsr_q | output | 32 | Current status word |
| spsr_q | output | 32 | Saved status word of the current mode, or the status word in USR/SYS |

## Verification
On every cycle, assertions check three things about the controller: a legal request lands in the requested state, an illegal code lands in USR, and the state stays put when there is no request. They also check that a captured saved status word holds the pre-switch status, and that low-register writes take effect. Bank isolation across mode round trips, sharing of the r8–r12 copy between non-FIQ modes, the old-bank target of a write coinciding with a switch, and the no-effect same-mode request can only be shown by the bench's scenarios. The bench compares read data against a reference model after sequences of writes and switches.

// File: rtl/mrf_pkg.sv
package mrf_pkg;

    typedef enum logic [4:0] {
        MD_USR = 5'b10000,
        MD_FIQ = 5'b10001,
        MD_IRQ = 5'b10010,
        MD_SVC = 5'b10011,
        MD_ABT = 5'b10111,
        MD_UND = 5'b11011,
        MD_SYS = 5'b11111
    } mode_e;

    localparam int NBANK = 6;
    localparam int BANKW = $clog2(NBANK);
    typedef logic [BANKW-1:0] bank_t;

    localparam bank_t BK_COMMON = bank_t'(0);
    localparam bank_t BK_FIQ    = bank_t'(1);

    // Illegal codes fall back to USR so no bank is ever chosen by garbage.
    function automatic mode_e decode_mode(input logic [4:0] code);
        mode_e m;
        case (code)
            5'b10001: m = MD_FIQ;
            5'b10010: m = MD_IRQ;
            5'b10011: m = MD_SVC;
            5'b10111: m = MD_ABT;
            5'b11011: m = MD_UND;
            5'b11111: m = MD_SYS;
            default:  m = MD_USR;
        endcase
        return m;
    endfunction

    function automatic bank_t bank_of(input mode_e m);
        bank_t b;
        unique case (m)
            MD_USR, MD_SYS: b = bank_t'(0);
            MD_FIQ:         b = bank_t'(1);
            MD_IRQ:         b = bank_t'(2);
            MD_SVC:         b = bank_t'(3);
            MD_ABT:         b = bank_t'(4);
            MD_UND:         b = bank_t'(5);
            default:        b = bank_t'(0);
        endcase
        return b;
    endfunction

endpackage

// File: rtl/mrf_mode_fsm.sv
module mrf_mode_fsm
    import mrf_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req,
    input  logic [4:0]  req_code,
    output mode_e       cur_mode,
    output bank_t       cur_bank,
    output bank_t       new_bank,
    output logic        switch_en
);

    mode_e state_q;
    mode_e req_mode;
    mode_e state_d;

    // Transition selection: SWITCH when the target differs, HOLD otherwise.
    always_comb begin
        req_mode  = decode_mode(req_code);
        switch_en = req && (req_mode != state_q);
        state_d   = switch_en ? req_mode : state_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= MD_SYS;
        else        state_q <= state_d;
    end

    always_comb begin
        cur_mode = state_q;
        cur_bank = bank_of(state_q);
        new_bank = bank_of(req_mode);
    end

    logic req_legal;
    always_comb req_legal = req_code inside {5'b10000, 5'b10001, 5'b10010, 5'b10011,
                                             5'b10111, 5'b11011, 5'b11111};

    p_legal_req_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req && req_legal) |=> (state_q == mode_e'($past(req_code))));

    p_illegal_to_usr_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !req_legal) |=> (state_q == MD_USR));

    p_idle_holds_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !req |=> $stable(state_q));

endmodule

// File: rtl/mrf_gpr_store.sv
module mrf_gpr_store
    import mrf_pkg::*;
#(
    parameter int XLEN = 32,
    parameter int NRD  = 2,
    parameter int IDXW = 4
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  bank_t                          bank,
    input  logic [XLEN-1:0]                pc,
    input  logic [NRD-1:0][IDXW-1:0]       rd_idx,
    output logic [NRD-1:0][XLEN-1:0]       rd_data,
    input  logic                           wr_en,
    input  logic [IDXW-1:0]                wr_idx,
    input  logic [XLEN-1:0]                wr_data
);

    localparam int NLOW  = 8;
    localparam int NHI   = 5;
    localparam int HI_LO = NLOW;
    localparam int SP_IX = NLOW + NHI;
    localparam int LR_IX = SP_IX + 1;

    logic [XLEN-1:0] low_q    [NLOW];
    logic [XLEN-1:0] hi_com_q [NHI];
    logic [XLEN-1:0] hi_fiq_q [NHI];
    logic [XLEN-1:0] sp_q     [NBANK];
    logic [XLEN-1:0] lr_q     [NBANK];

    logic in_fiq;
    always_comb in_fiq = (bank == BK_FIQ);

    function automatic logic [XLEN-1:0] peek(input logic [IDXW-1:0] idx);
        logic [IDXW-1:0] off;
        logic [XLEN-1:0] v;
        off = idx - IDXW'(HI_LO);
        if (int'(idx) < NLOW)        v = low_q[idx[2:0]];
        else if (int'(idx) < SP_IX)  v = in_fiq ? hi_fiq_q[off[2:0]] : hi_com_q[off[2:0]];
        else if (int'(idx) == SP_IX) v = sp_q[bank];
        else if (int'(idx) == LR_IX) v = lr_q[bank];
        else                         v = pc;
        return v;
    endfunction

    for (genvar p = 0; p < NRD; p++) begin : g_rd
        always_comb rd_data[p] = peek(rd_idx[p]);
    end

    logic [IDXW-1:0] wr_off;
    always_comb wr_off = wr_idx - IDXW'(HI_LO);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NLOW; i++) low_q[i] <= '0;
            for (int i = 0; i < NHI; i++) begin
                hi_com_q[i] <= '0;
                hi_fiq_q[i] <= '0;
            end
            for (int i = 0; i < NBANK; i++) begin
                sp_q[i] <= '0;
                lr_q[i] <= '0;
            end
        end else if (wr_en) begin
            // bank is the mode before any same-cycle switch
            if (int'(wr_idx) < NLOW)       low_q[wr_idx[2:0]] <= wr_data;
            else if (int'(wr_idx) < SP_IX) begin
                if (in_fiq) hi_fiq_q[wr_off[2:0]] <= wr_data;
                else        hi_com_q[wr_off[2:0]] <= wr_data;
            end
            else if (int'(wr_idx) == SP_IX) sp_q[bank] <= wr_data;
            else if (int'(wr_idx) == LR_IX) lr_q[bank] <= wr_data;
        end
    end

    p_low_write_lands_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && int'(wr_idx) < NLOW) |=> (low_q[$past(wr_idx[2:0])] == $past(wr_data)));

endmodule

// File: rtl/mrf_spsr_file.sv
module mrf_spsr_file
    import mrf_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            we,
    input  bank_t           wbank,
    input  logic [XLEN-1:0] wdata,
    input  bank_t           rbank,
    input  logic [XLEN-1:0] cpsr,
    output logic [XLEN-1:0] rdata
);

    localparam int NSAVED = NBANK - 1;

    logic [XLEN-1:0] saved_q [NSAVED];
    bank_t wslot, rslot;

    always_comb begin
        wslot = wbank - bank_t'(1);
        rslot = rbank - bank_t'(1);
        rdata = (rbank == BK_COMMON) ? cpsr : saved_q[rslot];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NSAVED; i++) saved_q[i] <= '0;
        end else if (we) begin
            saved_q[wslot] <= wdata;
        end
    end

    p_capture_r7: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> (saved_q[$past(wslot)] == $past(wdata)));

endmodule

// File: rtl/mode_banked_regfile.sv
module mode_banked_regfile
    import mrf_pkg::*;
#(
    parameter int          XLEN       = 32,
    parameter logic [31:0] CPSR_RESET = 32'h6000001F
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [3:0]      rd0_idx,
    output logic [XLEN-1:0] rd0_data,
    input  logic [3:0]      rd1_idx,
    output logic [XLEN-1:0] rd1_data,
    input  logic            wr_en,
    input  logic [3:0]      wr_idx,
    input  logic [XLEN-1:0] wr_data,
    input  logic [XLEN-1:0] pc_in,
    input  logic            mode_req,
    input  logic [4:0]      mode_code,
    output logic [XLEN-1:0] cpsr_q,
    output logic [XLEN-1:0] spsr_q
);

    localparam int NRD = 2;
    localparam logic [XLEN-6:0] CPSR_HI = CPSR_RESET[XLEN-1:5];

    mode_e cur_mode;
    bank_t cur_bank, new_bank;
    logic  switch_en;

    mrf_mode_fsm i_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .req       (mode_req),
        .req_code  (mode_code),
        .cur_mode  (cur_mode),
        .cur_bank  (cur_bank),
        .new_bank  (new_bank),
        .switch_en (switch_en)
    );

    always_comb cpsr_q = {CPSR_HI, cur_mode};

    logic [NRD-1:0][3:0]      rd_idx;
    logic [NRD-1:0][XLEN-1:0] rd_data;
    always_comb begin
        rd_idx[0] = rd0_idx;
        rd_idx[1] = rd1_idx;
        rd0_data  = rd_data[0];
        rd1_data  = rd_data[1];
    end

    mrf_gpr_store #(.XLEN(XLEN), .NRD(NRD), .IDXW(4)) i_gpr (
        .clk     (clk),
        .rst_n   (rst_n),
        .bank    (cur_bank),
        .pc      (pc_in),
        .rd_idx  (rd_idx),
        .rd_data (rd_data),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_data (wr_data)
    );

    logic spsr_we;
    always_comb spsr_we = switch_en && (new_bank != BK_COMMON);

    mrf_spsr_file #(.XLEN(XLEN)) i_spsr (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (spsr_we),
        .wbank (new_bank),
        .wdata (cpsr_q),
        .rbank (cur_bank),
        .cpsr  (cpsr_q),
        .rdata (spsr_q)
    );

    p_hi_bits_fixed_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cpsr_q[XLEN-1:5] == CPSR_HI);

endmodule

// File: tb/test_mode_banked_regfile.sv
`timescale 1ns/1ps
module test_mode_banked_regfile;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  rd0_idx = '0, rd1_idx = '0, wr_idx = '0;
    logic [31:0] rd0_data, rd1_data, wr_data = '0, pc_in = '0, cpsr_q, spsr_q;
    logic        wr_en = 1'b0, mode_req = 1'b0;
    logic [4:0]  mode_code = '0;

    always #10 clk = ~clk;

    mode_banked_regfile i_mode_banked_regfile (
        .clk(clk), .rst_n(rst_n),
        .rd0_idx(rd0_idx), .rd0_data(rd0_data),
        .rd1_idx(rd1_idx), .rd1_data(rd1_data),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
        .pc_in(pc_in), .mode_req(mode_req), .mode_code(mode_code),
        .cpsr_q(cpsr_q), .spsr_q(spsr_q)
    );

    int n_chk = 0, n_bad = 0;
    bit done = 0;

    // reference model
    logic [31:0] m_low[8], m_hc[5], m_hf[5], m_sp[6], m_lr[6], m_sv[6];
    logic [4:0]  m_mode;

    function automatic bit legal(input logic [4:0] c);
        return c inside {5'b10000, 5'b10001, 5'b10010, 5'b10011, 5'b10111, 5'b11011, 5'b11111};
    endfunction

    function automatic int bank(input logic [4:0] c);
        case (c)
            5'b10001: return 1;
            5'b10010: return 2;
            5'b10011: return 3;
            5'b10111: return 4;
            5'b11011: return 5;
            default:  return 0;
        endcase
    endfunction

    function automatic logic [31:0] exp_cpsr();
        return {27'h3000000, m_mode};
    endfunction

    function automatic logic [31:0] exp_reg(input logic [3:0] i, input logic [31:0] pc);
        int b = bank(m_mode);
        if (i < 8)  return m_low[i];
        if (i < 13) return (b == 1) ? m_hf[i-8] : m_hc[i-8];
        if (i == 13) return m_sp[b];
        if (i == 14) return m_lr[b];
        return pc;
    endfunction

    function automatic logic [31:0] exp_spsr();
        int b = bank(m_mode);
        return (b == 0) ? exp_cpsr() : m_sv[b];
    endfunction

    function automatic string tag_of(input logic [3:0] i);
        if (i < 8)  return "R5";
        if (i < 13) return "R4";
        if (i < 15) return "R3";
        return "R10";
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < 8; i++) m_low[i] = '0;
        for (int i = 0; i < 5; i++) begin m_hc[i] = '0; m_hf[i] = '0; end
        for (int i = 0; i < 6; i++) begin m_sp[i] = '0; m_lr[i] = '0; m_sv[i] = '0; end
        m_mode = 5'b11111;
    endtask

    // called at negedge; returns at the next negedge
    task automatic tick(input bit we, input logic [3:0] wi, input logic [31:0] wd,
                        input bit rq, input logic [4:0] code);
        logic [4:0] tgt;
        int b;
        wr_en = we; wr_idx = wi; wr_data = wd; mode_req = rq; mode_code = code;
        @(posedge clk);
        b = bank(m_mode);
        if (we) begin
            if (wi < 8)       m_low[wi] = wd;
            else if (wi < 13) begin if (b == 1) m_hf[wi-8] = wd; else m_hc[wi-8] = wd; end
            else if (wi == 13) m_sp[b] = wd;
            else if (wi == 14) m_lr[b] = wd;
        end
        if (rq) begin
            tgt = legal(code) ? code : 5'b10000;
            if (tgt != m_mode) begin
                if (bank(tgt) != 0) m_sv[bank(tgt)] = exp_cpsr();
                m_mode = tgt;
            end
        end
        @(negedge clk);
        wr_en = 0; mode_req = 0;
    endtask

    task automatic rd(input string tag, input logic [3:0] i);
        rd0_idx = i;
        rd1_idx = 4'(i + 4'd5);
        pc_in = $urandom;
        #1;
        chk(tag, rd0_data, exp_reg(i, pc_in));
        chk(tag_of(rd1_idx), rd1_data, exp_reg(rd1_idx, pc_in));
    endtask

    task automatic st(input string tag);
        chk(tag, cpsr_q, exp_cpsr());
        chk("R7", spsr_q, exp_spsr());
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired (all requirements)");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED1234));
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        #1;
        // R1 reset state
        chk("R1", cpsr_q, 32'h6000001F);
        chk("R1", spsr_q, 32'h6000001F);
        for (int i = 0; i < 15; i++) rd("R1", 4'(i));

        // R3 / R2 / R7: SYS -> FIQ
        tick(1, 4'd13, 32'h1111, 0, 0);
        tick(0, 0, 0, 1, 5'b10001);
        chk("R2", cpsr_q, 32'h60000011);
        chk("R7", spsr_q, 32'h6000001F);
        rd("R3", 4'd13);
        chk("R3", rd0_data, 32'h0);
        tick(1, 4'd13, 32'h2222, 0, 0);
        tick(1, 4'd8, 32'h88, 0, 0);
        rd("R4", 4'd8);
        chk("R4", rd0_data, 32'h88);
        // R4: FIQ -> IRQ, r8 back to common copy
        tick(0, 0, 0, 1, 5'b10010);
        rd("R4", 4'd8);
        chk("R4", rd0_data, 32'h0);
        tick(1, 4'd9, 32'h99, 0, 0);
        tick(1, 4'd3, 32'h33, 0, 0);
        tick(0, 0, 0, 1, 5'b11111);
        rd("R4", 4'd9);
        chk("R4", rd0_data, 32'h99);
        rd("R3", 4'd13);
        chk("R3", rd0_data, 32'h1111);
        rd("R5", 4'd3);
        chk("R5", rd0_data, 32'h33);

        // R6: same-mode request
        tick(0, 0, 0, 1, 5'b11111);
        st("R6");
        chk("R6", cpsr_q, 32'h6000001F);
        tick(0, 0, 0, 1, 5'b10011);
        chk("R7", spsr_q, 32'h6000001F);
        tick(1, 4'd14, 32'h5151, 0, 0);
        tick(0, 0, 0, 1, 5'b10011);
        chk("R6", spsr_q, 32'h6000001F);
        chk("R6", cpsr_q, 32'h60000013);
        rd("R6", 4'd14);
        chk("R6", rd0_data, 32'h5151);

        // R8: illegal code
        tick(0, 0, 0, 1, 5'b00101);
        chk("R8", cpsr_q, 32'h60000010);
        rd("R8", 4'd13);
        chk("R8", rd0_data, 32'h1111);

        // R9: write coinciding with switch USR -> ABT
        tick(1, 4'd14, 32'hABCD, 1, 5'b10111);
        rd("R9", 4'd14);
        chk("R9", rd0_data, 32'h0);
        tick(0, 0, 0, 1, 5'b10000);
        rd("R9", 4'd14);
        chk("R9", rd0_data, 32'hABCD);

        // R10: r15 write ignored, read returns pc_in; write visible next cycle
        tick(1, 4'd15, 32'hDEAD, 0, 0);
        rd("R10", 4'd15);
        for (int i = 0; i < 15; i++) rd("R10", 4'(i));
        rd0_idx = 4'd2;
        wr_en = 1; wr_idx = 4'd2; wr_data = 32'h2468;
        #1;
        chk("R10", rd0_data, m_low[2]);
        wr_en = 0;
        tick(1, 4'd2, 32'h2468, 0, 0);
        rd("R10", 4'd2);
        chk("R10", rd0_data, 32'h2468);

        // random mix
        for (int n = 0; n < 600; n++) begin
            logic [4:0] code;
            logic [3:0] wi;
            int sel = $urandom_range(0, 9);
            case ($urandom_range(0, 7))
                0: code = 5'b10000; 1: code = 5'b10001; 2: code = 5'b10010;
                3: code = 5'b10011; 4: code = 5'b10111; 5: code = 5'b11011;
                6: code = 5'b11111; default: code = 5'($urandom);
            endcase
            wi = 4'($urandom);
            tick(sel < 7, wi, $urandom, sel > 4, code);
            st(legal(code) ? "R2" : "R8");
            rd(sel > 4 && sel < 7 ? "R9" : tag_of(wi), wi);
        end

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule